// File: doc/BRIEF.md
# CRC-4 Command Word Framer and Checker

This block guards 16-bit command and status words whose upper 12 bits are a payload and whose lower 4 bits are a check field. In generate mode it takes a 12-bit message, divides it (with four zeros appended) by the polynomial x^4 + x + 1 in modulo-2 arithmetic, and places the bitwise inverse of the 4-bit remainder below the message to form the word to send. In check mode it takes a received 16-bit word, un-inverts its check field, divides the whole word by the same polynomial and reports the word as good only when the remainder is zero.

A parameter picks one of two forms. With `SERIAL = 0` the block is a purely combinational XOR network: both the generated word and the check verdict are available in the same cycle from `msg_in` and `word_in`. With `SERIAL = 1` the block is a small state machine that takes one bit per clock, MSB first, and raises `done` when the message (12 bits) or the word (16 bits) is complete. The serial machine has three states: `S_IDLE` (after reset, nothing loaded), `S_SHIFT` (accepting bits) and `S_DONE` (result held). Transitions: any state to `S_SHIFT` on `start`; `S_SHIFT` to `S_DONE` when the last bit of the frame is accepted; `S_SHIFT` stays in `S_SHIFT` on other cycles; `S_IDLE` and `S_DONE` hold without `start`.

Top module: `crc4_guard`

## Requirements
- R1: `crc_out` is the remainder of (message * x^4) divided by x^4 + x + 1 (divisor bits 10011), with message bit 11 taken first; message 110000010000 gives 1101.
- R2: In generate mode `tx_word[15:4]` is the message and `tx_word[3:0]` is the bitwise inverse of the remainder; message 110000010000 gives 1100000100000010.
- R3: In check mode bits [3:0] of the received word are inverted, the 16-bit result is divided by 10011, and `word_ok` is 1 exactly when the remainder is 0000; 1100000100000010 is good.
- R4: Any received word that differs from a correctly generated word in exactly one bit gives `word_ok` = 0.
- R5: A word carrying the remainder uninverted in bits [3:0] gives `word_ok` = 0 whenever that remainder is neither 0000 nor 1111.
- R6: With `SERIAL = 0` the outputs follow `msg_in` (generate results) and `word_in` (check result) in the same cycle, and `done` is constantly 1.
- R7: With `SERIAL = 1`, after reset and in the cycle after `start` the remainder is 0000 and `done` is 0; `start` samples `mode_chk` (0 = generate, 1 = check) and a bit presented with `start` is not taken.
- R8: With `SERIAL = 1` one bit is taken on each clock where `in_valid` is 1; cycles with `in_valid` = 0 take nothing; `done` is 1 from the clock after the 12th (generate) or 16th (check) accepted bit.
- R9: With `SERIAL = 1`, once `done` is 1 further bits are not taken and all outputs hold until the next `start`; in check mode `tx_word` echoes the received word and `word_ok` is 0 while `done` is 0.
- R10: The serial and parallel forms give the same `crc_out` and `tx_word` for all 4096 messages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the serial form) |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Serial form: clear remainder and begin a new frame |
| mode_chk | input | 1 | Serial form: 0 generate, 1 check; sampled with `start` |
| in_valid | input | 1 | Serial form: `in_bit` is taken this clock |
| in_bit | input | 1 | Serial form: next frame bit, MSB first |
| msg_in | input | 12 | Parallel form: message to protect |
| word_in | input | 16 | Parallel form: received word to check |
| tx_word | output | 16 | Message with inverted CRC appended (check mode, serial: received word) |
| crc_out | output | 4 | Remainder of the division (not inverted) |
| word_ok | output | 1 | Received word passes the check |
| done | output | 1 | Result valid (constant 1 in the parallel form) |

## Verification
The bench walks every message through both forms against an explicit long-division model, so a wrong feedback tap or bit order would show up as a mismatched remainder on most messages, and a missing inversion on the check field would corrupt every transmitted word. It flips each of the 16 bits of good words and sends remainders uninverted, which catches a checker that forgets to re-invert the field or that tests only part of the remainder. The serial runs insert idle gaps, present a bit together with `start`, keep driving bits after `done` and restart in mid-frame; a machine that counts idle cycles, takes the bit under `start`, keeps shifting after completion or keeps stale remainder bits would produce a wrong result or a misplaced `done`.

// File: rtl/crc4_pkg.sv
package crc4_pkg;
    localparam int MSG_W  = 12;
    localparam int CRC_W  = 4;
    localparam int WORD_W = MSG_W + CRC_W;
    // Low terms of x^4 + x + 1; the x^4 term is the shifted-out bit.
    localparam logic [CRC_W-1:0] POLY_LOW = 4'b0011;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SHIFT = 2'd1,
        S_DONE  = 2'd2
    } ser_state_t;

    // One division step: feed a bit into the remainder register.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] rem, input logic b);
        logic fb;
        fb = rem[CRC_W-1] ^ b;
        return {rem[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & POLY_LOW);
    endfunction
endpackage

// File: rtl/crc4_parallel.sv
module crc4_parallel
    import crc4_pkg::*;
(
    input  logic [MSG_W-1:0]  msg_in,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] tx_word,
    output logic [CRC_W-1:0]  crc_out,
    output logic              word_ok
);
    logic [CRC_W-1:0]  gen_rem;
    logic [CRC_W-1:0]  chk_rem;
    logic [WORD_W-1:0] restored;

    // Unrolled steps form a network of 2-input XORs.
    always_comb begin
        gen_rem = '0;
        for (int i = MSG_W - 1; i >= 0; i--) begin
            gen_rem = crc_step(gen_rem, msg_in[i]);
        end
    end

    assign restored = {word_in[WORD_W-1:CRC_W], ~word_in[CRC_W-1:0]};

    always_comb begin
        chk_rem = '0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            chk_rem = crc_step(chk_rem, restored[i]);
        end
    end

    assign crc_out = gen_rem;
    assign tx_word = {msg_in, ~gen_rem};
    assign word_ok = (chk_rem == '0);

    // A word this block generates must pass this block's checker.
    logic [CRC_W-1:0] loop_rem;
    always_comb begin
        loop_rem = '0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            loop_rem = crc_step(loop_rem, (i < CRC_W) ? ~tx_word[i] : tx_word[i]);
        end
        AST_OWN_WORD_PASSES: assert (loop_rem == '0); // R3
    end
endmodule

// File: rtl/crc4_serial.sv
module crc4_serial
    import crc4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_chk,
    input  logic              in_valid,
    input  logic              in_bit,
    output logic [WORD_W-1:0] tx_word,
    output logic [CRC_W-1:0]  crc_out,
    output logic              word_ok,
    output logic              done
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] GEN_LAST = CNT_W'(MSG_W - 1);
    localparam logic [CNT_W-1:0] CHK_LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] CHK_FROM = CNT_W'(MSG_W);

    ser_state_t        state, nxt;
    logic [CRC_W-1:0]  rem_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] data_q;
    logic              chk_q;
    logic              take;
    logic              last_bit;
    logic              fed_bit;

    assign take     = (state == S_SHIFT) && in_valid && !start;
    assign last_bit = (cnt_q == (chk_q ? CHK_LAST : GEN_LAST));
    // The check field arrives inverted: restore it before dividing.
    assign fed_bit  = (chk_q && (cnt_q >= CHK_FROM)) ? ~in_bit : in_bit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = S_SHIFT;
            S_SHIFT: begin
                if (start)                 nxt = S_SHIFT;
                else if (take && last_bit) nxt = S_DONE;
            end
            S_DONE:  if (start) nxt = S_SHIFT;
            default: nxt = S_IDLE;
        endcase
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            cnt_q  <= '0;
            data_q <= '0;
            chk_q  <= 1'b0;
        end else if (start) begin
            rem_q  <= '0;
            cnt_q  <= '0;
            data_q <= '0;
            chk_q  <= mode_chk;
        end else if (take) begin
            rem_q  <= crc_step(rem_q, fed_bit);
            cnt_q  <= cnt_q + 1'b1;
            data_q <= {data_q[WORD_W-2:0], in_bit};
        end
    end

    // Outputs
    always_comb begin
        done    = (state == S_DONE);
        crc_out = rem_q;
        word_ok = done && chk_q && (rem_q == '0);
        tx_word = chk_q ? data_q : {data_q[MSG_W-1:0], ~rem_q};
    end

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (rem_q == '0) && !done); // R7
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done && $stable(rem_q) && $stable(data_q)); // R9
    AST_DONE_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(in_valid) && !$past(start)); // R8
    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(WORD_W)); // R8
    AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt_q == (chk_q ? CNT_W'(WORD_W) : CNT_W'(MSG_W)))); // R8
endmodule

// File: rtl/crc4_guard.sv
module crc4_guard
    import crc4_pkg::*;
#(
    parameter bit SERIAL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_chk,
    input  logic              in_valid,
    input  logic              in_bit,
    input  logic [MSG_W-1:0]  msg_in,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] tx_word,
    output logic [CRC_W-1:0]  crc_out,
    output logic              word_ok,
    output logic              done
);
    generate
        if (SERIAL) begin : g_serial
            logic unused_par;
            assign unused_par = ^{msg_in, word_in};
            crc4_serial u_ser (
                .clk      (clk),
                .rst_n    (rst_n),
                .start    (start),
                .mode_chk (mode_chk),
                .in_valid (in_valid),
                .in_bit   (in_bit),
                .tx_word  (tx_word),
                .crc_out  (crc_out),
                .word_ok  (word_ok),
                .done     (done)
            );
        end else begin : g_parallel
            logic unused_ser;
            assign unused_ser = ^{clk, rst_n, start, mode_chk, in_valid, in_bit};
            crc4_parallel u_par (
                .msg_in  (msg_in),
                .word_in (word_in),
                .tx_word (tx_word),
                .crc_out (crc_out),
                .word_ok (word_ok)
            );
            assign done = 1'b1;
        end
    endgenerate
endmodule

// File: tb/crc4_guard_tb.sv
module crc4_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, mode_chk = 1'b0, in_valid = 1'b0, in_bit = 1'b0;
    logic [11:0] msg_in = '0;
    logic [15:0] word_in = '0;
    logic [15:0] s_tx, p_tx;
    logic [3:0]  s_crc, p_crc;
    logic        s_ok, p_ok, s_done, p_done;
    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    crc4_guard #(.SERIAL(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_chk(mode_chk),
        .in_valid(in_valid), .in_bit(in_bit), .msg_in(msg_in), .word_in(word_in),
        .tx_word(s_tx), .crc_out(s_crc), .word_ok(s_ok), .done(s_done));

    crc4_guard #(.SERIAL(1'b0)) u_par (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_chk(mode_chk),
        .in_valid(in_valid), .in_bit(in_bit), .msg_in(msg_in), .word_in(word_in),
        .tx_word(p_tx), .crc_out(p_crc), .word_ok(p_ok), .done(p_done));

    // Behavioural long division: 16-bit dividend, divisor 10011.
    function automatic logic [3:0] divide(input logic [15:0] d);
        logic [15:0] r;
        r = d;
        for (int i = 15; i >= 4; i--) begin
            if (r[i]) r[i -: 5] = r[i -: 5] ^ 5'b10011;
        end
        return r[3:0];
    endfunction

    function automatic logic [3:0] ref_crc(input logic [11:0] m);
        return divide({m, 4'b0000});
    endfunction

    function automatic logic ref_ok(input logic [15:0] w);
        return divide({w[15:4], ~w[3:0]}) == 4'b0000;
    endfunction

    task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Serial frame: start pulse (with a stray bit that must be ignored), then n bits MSB first.
    task automatic ser_frame(input logic chk, input logic [15:0] w, input int n, input bit gaps);
        @(negedge clk);
        start = 1'b1; mode_chk = chk; in_valid = 1'b1; in_bit = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < n; k++) begin
            if (gaps && (k % 3 == 1)) begin
                in_valid = 1'b0; in_bit = ~in_bit;
                @(negedge clk);
            end
            in_valid = 1'b1; in_bit = w[n - 1 - k];
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R7", "reset done", {15'd0, s_done}, 16'd0);
        check("R7", "reset crc", {12'd0, s_crc}, 16'd0);
        check("R9", "reset word_ok", {15'd0, s_ok}, 16'd0);
    endtask

    task automatic t_par_example();
        msg_in = 12'b110000010000; word_in = 16'b1100000100000010;
        #1;
        check("R1", "par example crc", {12'd0, p_crc}, 16'b1101);
        check("R2", "par example word", p_tx, 16'b1100000100000010);
        check("R3", "par example ok", {15'd0, p_ok}, 16'd1);
        check("R6", "par done", {15'd0, p_done}, 16'd1);
    endtask

    task automatic t_par_errors();
        logic [11:0] ms [4] = '{12'b110000010000, 12'hA5C, 12'h001, 12'hFFE};
        foreach (ms[j]) begin
            logic [15:0] good;
            logic [3:0]  c;
            c = ref_crc(ms[j]);
            good = {ms[j], ~c};
            word_in = good; #1;
            check("R3", "good word ok", {15'd0, p_ok}, 16'd1);
            for (int b = 0; b < 16; b++) begin
                word_in = good ^ (16'd1 << b); #1;
                check("R4", "single flip", {15'd0, p_ok}, 16'd0);
            end
            word_in = {ms[j], c}; #1;
            if (c != 4'b0000 && c != 4'b1111)
                check("R5", "uninverted crc", {15'd0, p_ok}, 16'd0);
        end
    endtask

    task automatic t_ser_gen_example();
        ser_frame(1'b0, {4'd0, 12'b110000010000}, 12, 1'b1);
        check("R8", "gen done", {15'd0, s_done}, 16'd1);
        check("R1", "ser example crc", {12'd0, s_crc}, 16'b1101);
        check("R2", "ser example word", s_tx, 16'b1100000100000010);
    endtask

    task automatic t_ser_done_timing();
        // done must be low one accepted bit short of the frame.
        @(negedge clk);
        start = 1'b1; mode_chk = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 11; k++) begin
            in_valid = 1'b1; in_bit = 1'b0;
            @(negedge clk);
        end
        in_valid = 1'b0;
        check("R7", "start cleared crc", {12'd0, s_crc}, 16'd0);
        check("R8", "done early", {15'd0, s_done}, 16'd0);
        @(negedge clk);
        check("R8", "idle gap no bit", {15'd0, s_done}, 16'd0);
        in_valid = 1'b1; in_bit = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8", "done on 12th", {15'd0, s_done}, 16'd1);
        check("R1", "msg 001 crc", {12'd0, s_crc}, {12'd0, ref_crc(12'h001)});
    endtask

    task automatic t_ser_check();
        ser_frame(1'b1, 16'b1100000100000010, 16, 1'b1);
        check("R3", "ser check good", {15'd0, s_ok}, 16'd1);
        check("R9", "check echoes word", s_tx, 16'b1100000100000010);
        ser_frame(1'b1, 16'b1100000100000010 ^ 16'h0100, 16, 1'b0);
        check("R4", "ser check flip", {15'd0, s_ok}, 16'd0);
        ser_frame(1'b1, 16'b1100000100001101, 16, 1'b0);
        check("R5", "ser uninverted", {15'd0, s_ok}, 16'd0);
    endtask

    task automatic t_ser_after_done();
        ser_frame(1'b0, {4'd0, 12'hA5C}, 12, 1'b0);
        for (int k = 0; k < 5; k++) begin
            in_valid = 1'b1; in_bit = k[0];
            @(negedge clk);
        end
        in_valid = 1'b0;
        check("R9", "hold crc", {12'd0, s_crc}, {12'd0, ref_crc(12'hA5C)});
        check("R9", "hold word", s_tx, {12'hA5C, ~ref_crc(12'hA5C)});
        check("R9", "hold done", {15'd0, s_done}, 16'd1);
    endtask

    task automatic t_ser_restart();
        // Abort a frame midway; the new frame must not inherit old bits.
        @(negedge clk);
        start = 1'b1; mode_chk = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 7; k++) begin
            in_valid = 1'b1; in_bit = 1'b1;
            @(negedge clk);
        end
        ser_frame(1'b0, {4'd0, 12'h3C7}, 12, 1'b0);
        check("R7", "restart crc", {12'd0, s_crc}, {12'd0, ref_crc(12'h3C7)});
    endtask

    task automatic t_exhaustive();
        int bad = 0;
        for (int m = 0; m < 4096; m++) begin
            logic [11:0] mm;
            mm = 12'(m);
            msg_in = mm;
            ser_frame(1'b0, {4'd0, mm}, 12, 1'b0);
            checks++;
            if (p_crc !== ref_crc(mm) || s_crc !== ref_crc(mm) ||
                p_tx !== {mm, ~ref_crc(mm)} || s_tx !== p_tx) begin
                errors++; bad++;
                if (bad < 5)
                    $display("FAIL R10 msg %h: ser %h/%h par %h/%h expected crc %h",
                             mm, s_crc, s_tx, p_crc, p_tx, ref_crc(mm));
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_par_example();
        t_par_errors();
        t_ser_gen_example();
        t_ser_done_timing();
        t_ser_check();
        t_ser_after_done();
        t_ser_restart();
        t_exhaustive();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule